// File: doc/BRIEF.md
# Counter/TDC Skew Glitch Corrector

This block sits in the reference-clock domain of a fractional-N digital PLL, between the differentiated outputs of the integer period counter and the time-to-digital converter (TDC) and the loop filter input. A small timing skew between the counter clock and the TDC input can make the counter step arrive one reference cycle before or after the TDC wrap that should go with it. The sum of the two then shows a bipolar glitch of one whole count, and that glitch produces spurs at the synthesizer output.

The corrector looks at the integer error and the TDC wrap events as separate inputs. When a wrap arrives without its counter step, it adds or removes one integer count so that the error stays clean. It also records the pending correction in a signed flag. When the late counter step arrives without a wrap, the flag releases the opposite correction. The flag saturates at plus or minus one. Because of this, a real frequency step loses only its first sample and then passes through. When the integer error leaves the locked set {0, 1}, data passes through unchanged. The fractional control word's top bit selects between the overflow rule (fraction below one half) and the mirrored underflow rule.

Top module: `glitch_corrector`

## Requirements
- R1: While reset is held, and on the first cycles after it, `err_out` is 0 and `corr_flag` is 0. `corr_flag` is a 2-bit two's-complement value limited to -1 (2'b11), 0 (2'b00) and +1 (2'b01).
- R2: With no correction, `err_out` equals `fcw_frac - cnt_err*2^FRAC_W - tdc_diff`, computed from the inputs sampled on one rising edge and presented after that edge (one cycle of latency). `cnt_err` and `tdc_diff` are two's complement and `fcw_frac` is unsigned.
- R3: When `cnt_err` is neither 0 nor 1, no correction is applied and `corr_flag` keeps its value.
- R4: When `fcw_frac` MSB is 0, `tdc_ovf` is 1, `cnt_err` is 0 and the flag is not -1, one count is added (`err_out` is 16 LSBs, i.e. 2^FRAC_W, below the R2 value) and the flag decreases by 1.
- R5: When `fcw_frac` MSB is 0, `cnt_err` is 1, `tdc_ovf` is 0 and the flag is not +1, one count is removed (`err_out` is 2^FRAC_W above the R2 value) and the flag increases by 1. Starting from -1, this returns the flag to 0.
- R6: When `fcw_frac` MSB is 1, the rules mirror. If `tdc_unf` is 1, `cnt_err` is 1 and the flag is not +1, one count is removed (`err_out` is 2^FRAC_W above the R2 value) and the flag increases. If `cnt_err` is 0, `tdc_unf` is 0 and the flag is not -1, one count is added and the flag decreases.
- R7: When the flag is already saturated in the direction of a rule, that rule does not fire. So a sustained genuine step (for example, `cnt_err` staying at 1 with no overflow when the MSB is 0) has only its first sample corrected.
- R8: A step and a wrap in the same cycle, or neither of them, causes no correction and leaves the flag unchanged.
- R9: With `corr_en` at 0, `err_out` follows R2 exactly and the flag is cleared to 0 on the next edge.
- R10: The wrap flag of the unselected direction is ignored: `tdc_unf` when the MSB is 0, and `tdc_ovf` when the MSB is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| corr_en | input | 1 | 1 enables correction; 0 bypasses it and clears the flag |
| fcw_frac | input | FRAC_W | Fractional part of the frequency control word (unsigned) |
| cnt_err | input | CNT_W | Integer error: counter period count minus integer control word (signed) |
| tdc_diff | input | TDC_W | Differentiated TDC code, in fractional LSBs (signed) |
| tdc_ovf | input | 1 | TDC wrapped forward this cycle |
| tdc_unf | input | 1 | TDC wrapped backward this cycle |
| err_out | output | ERR_W | Corrected frequency error, in fractional LSBs (signed, registered) |
| corr_flag | output | 2 | Pending-correction flag (signed, registered) |

## Verification
The bench builds the block with CNT_W = 6 and FRAC_W = 4, so TDC_W = 6 and ERR_W = 12. With these values one integer count is 16 output LSBs, which makes each correction easy to see. The narrow integer field also lets random stimulus reach both extremes of `cnt_err` and plenty of values outside the locked set. Directed skew sequences in both fractional halves, and a held genuine step, take the flag through every state and every saturation edge. Random traffic covers the unlocked, matched and ignored-wrap cases.

// File: rtl/gc_pkg.sv
package gc_pkg;

  // Pending-correction flag: two's complement, limited to -1, 0, +1
  typedef logic signed [1:0] flag_t;

  localparam flag_t FLAG_NEG  = -2'sd1;
  localparam flag_t FLAG_ZERO = 2'sd0;
  localparam flag_t FLAG_POS  = 2'sd1;

  // Direction of the expected wrap, taken from the fraction MSB
  typedef enum logic {
    DIR_FWD = 1'b0,   // fraction below one half: TDC overflows
    DIR_REV = 1'b1    // fraction at or above one half: TDC underflows
  } wrap_dir_e;

  // Decoded events for one reference cycle
  typedef struct packed {
    logic      locked;
    logic      step;
    logic      wrap;
    wrap_dir_e dir;
  } gc_events_t;

  // Sign of the rules for a direction: +1 forward, -1 reverse
  function automatic flag_t dir_sign(input wrap_dir_e d);
    return (d == DIR_FWD) ? FLAG_POS : FLAG_NEG;
  endfunction

  // Negate a flag value (only ever applied to +1 or -1)
  function automatic flag_t flag_neg(input flag_t f);
    return -f;
  endfunction

endpackage

// File: rtl/gc_reset_sync.sv
module gc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/gc_event_decode.sv
module gc_event_decode
  import gc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic [FRAC_W-1:0] fcw_frac,
  input  logic [CNT_W-1:0]  cnt_err,
  input  logic              tdc_ovf,
  input  logic              tdc_unf,
  output gc_events_t        ev
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic      is_zero;
  logic      is_one;
  wrap_dir_e dir;

  always_comb begin
    is_zero = (cnt_err == CNT_ZERO);
    is_one  = (cnt_err == CNT_ONE);
    dir     = wrap_dir_e'(fcw_frac[FRAC_W-1]);

    ev.dir    = dir;
    ev.locked = is_zero | is_one;
    if (dir == DIR_FWD) begin
      // forward sweep: the counter steps up with an overflow
      ev.step = is_one;
      ev.wrap = tdc_ovf;
    end else begin
      // backward sweep: the counter steps down with an underflow
      ev.step = is_zero;
      ev.wrap = tdc_unf;
    end
  end

endmodule

// File: rtl/gc_pair_tracker.sv
module gc_pair_tracker
  import gc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync_n,
  input  logic       corr_en,
  input  gc_events_t ev,
  output flag_t      corr_cnt,
  output flag_t      flag_q
);

  flag_t sgn;
  flag_t flag_d;
  logic  lone_wrap;
  logic  lone_step;
  logic  flag_ce;

  always_comb begin
    sgn       = dir_sign(ev.dir);
    lone_wrap = ev.wrap & ~ev.step;
    lone_step = ev.step & ~ev.wrap;
    corr_cnt  = FLAG_ZERO;
    flag_d    = flag_q;

    if (!corr_en) begin
      flag_d = FLAG_ZERO;
    end else if (ev.locked) begin
      if (lone_wrap && (flag_q != flag_neg(sgn))) begin
        // wrap ahead of its counter step: supply the missing count
        corr_cnt = sgn;
        flag_d   = flag_q - sgn;
      end else if (lone_step && (flag_q != sgn)) begin
        // counter step with no wrap: take the count back out
        corr_cnt = flag_neg(sgn);
        flag_d   = flag_q + sgn;
      end
    end

    flag_ce = (flag_d != flag_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_q <= FLAG_ZERO;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/gc_error_form.sv
module gc_error_form
  import gc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 4,
  parameter int TDC_W  = FRAC_W + 2,
  parameter int ERR_W  = CNT_W + FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic [FRAC_W-1:0] fcw_frac,
  input  logic [CNT_W-1:0]  cnt_err,
  input  logic [TDC_W-1:0]  tdc_diff,
  input  flag_t             corr_cnt,
  output logic [ERR_W-1:0]  err_q
);

  localparam int CC_W = CNT_W + 1;

  logic signed [CC_W-1:0]  cnt_fixed;
  logic signed [ERR_W-1:0] frac_ext;
  logic signed [ERR_W-1:0] cnt_ext;
  logic signed [ERR_W-1:0] tdc_ext;
  logic signed [ERR_W-1:0] err_d;

  always_comb begin
    cnt_fixed = CC_W'($signed(cnt_err)) + CC_W'(corr_cnt);
    frac_ext  = ERR_W'({1'b0, fcw_frac});
    cnt_ext   = ERR_W'(cnt_fixed) <<< FRAC_W;
    tdc_ext   = ERR_W'($signed(tdc_diff));
    err_d     = frac_ext - cnt_ext - tdc_ext;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q <= '0;
    end else begin
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/glitch_corrector.sv
module glitch_corrector
  import gc_pkg::*;
#(
  parameter  int CNT_W  = 8,
  parameter  int FRAC_W = 4,
  localparam int TDC_W  = FRAC_W + 2,
  localparam int ERR_W  = CNT_W + FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              corr_en,
  input  logic [FRAC_W-1:0] fcw_frac,
  input  logic [CNT_W-1:0]  cnt_err,
  input  logic [TDC_W-1:0]  tdc_diff,
  input  logic              tdc_ovf,
  input  logic              tdc_unf,
  output logic [ERR_W-1:0]  err_out,
  output logic [1:0]        corr_flag
);

  logic       rst_sync_n;
  gc_events_t ev;
  flag_t      corr_cnt;
  flag_t      flag_q;

  gc_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gc_event_decode #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_dec (
    .fcw_frac (fcw_frac),
    .cnt_err  (cnt_err),
    .tdc_ovf  (tdc_ovf),
    .tdc_unf  (tdc_unf),
    .ev       (ev)
  );

  gc_pair_tracker u_trk (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .corr_en    (corr_en),
    .ev         (ev),
    .corr_cnt   (corr_cnt),
    .flag_q     (flag_q)
  );

  gc_error_form #(
    .CNT_W (CNT_W),
    .FRAC_W(FRAC_W),
    .TDC_W (TDC_W),
    .ERR_W (ERR_W)
  ) u_err (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .fcw_frac   (fcw_frac),
    .cnt_err    (cnt_err),
    .tdc_diff   (tdc_diff),
    .corr_cnt   (corr_cnt),
    .err_q      (err_out)
  );

  assign corr_flag = flag_q;

endmodule

// File: rtl/gc_checker.sv
module gc_checker #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 4,
  parameter int TDC_W  = FRAC_W + 2,
  parameter int ERR_W  = CNT_W + FRAC_W + 2
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              corr_en,
  input logic [FRAC_W-1:0] fcw_frac,
  input logic [CNT_W-1:0]  cnt_err,
  input logic [TDC_W-1:0]  tdc_diff,
  input logic              tdc_ovf,
  input logic              tdc_unf,
  input logic [ERR_W-1:0]  err_out,
  input logic [1:0]        corr_flag
);

  localparam int ONE_CNT = 1 << FRAC_W;

  int   raw_c;
  int   raw_q;
  int   delta;
  logic armed_q;
  logic locked_c;

  always_comb begin
    raw_c    = int'(fcw_frac) - int'($signed(cnt_err)) * ONE_CNT
               - int'($signed(tdc_diff));
    delta    = int'($signed(err_out)) - raw_q;
    locked_c = (cnt_err == '0) || (cnt_err == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      armed_q <= 1'b0;
      raw_q   <= 0;
    end else begin
      armed_q <= 1'b1;
      raw_q   <= raw_c;
    end
  end

  // R1: the flag never takes the unused code
  assert_flag_code_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    corr_flag != 2'b10);

  // R2: the output differs from the raw error by at most one count
  assert_corr_bound_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    armed_q |-> (delta == 0 || delta == ONE_CNT || delta == -ONE_CNT));

  // R3: out of lock the flag holds
  assert_unlock_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (corr_en && !locked_c) |=> $stable(corr_flag));

  // R3: out of lock the output is the raw error
  assert_unlock_pass_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed_q && corr_en && !locked_c) |=> (delta == 0));

  // R9: bypass clears the flag and leaves the error raw
  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed_q && !corr_en) |=> (corr_flag == 2'b00 && delta == 0));

  // R8: step and wrap together leave the flag alone
  assert_matched_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (corr_en && !fcw_frac[FRAC_W-1] && tdc_ovf && cnt_err == CNT_W'(1))
    |=> $stable(corr_flag));

endmodule

bind glitch_corrector gc_checker #(
  .CNT_W (CNT_W),
  .FRAC_W(FRAC_W),
  .TDC_W (TDC_W),
  .ERR_W (ERR_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .corr_en    (corr_en),
  .fcw_frac   (fcw_frac),
  .cnt_err    (cnt_err),
  .tdc_diff   (tdc_diff),
  .tdc_ovf    (tdc_ovf),
  .tdc_unf    (tdc_unf),
  .err_out    (err_out),
  .corr_flag  (corr_flag)
);

// File: tb/glitch_corrector_test.sv
module glitch_corrector_test;

  localparam int CNT_W  = 6;
  localparam int FRAC_W = 4;
  localparam int TDC_W  = FRAC_W + 2;
  localparam int ERR_W  = CNT_W + FRAC_W + 2;
  localparam int ONE    = 1 << FRAC_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              corr_en;
  logic [FRAC_W-1:0] fcw_frac;
  logic [CNT_W-1:0]  cnt_err;
  logic [TDC_W-1:0]  tdc_diff;
  logic              tdc_ovf;
  logic              tdc_unf;
  logic [ERR_W-1:0]  err_out;
  logic [1:0]        corr_flag;

  int n_checks = 0;
  int n_fail   = 0;
  int m_flag   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  glitch_corrector #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) uut (
    .clk(clk), .rst_n(rst_n), .corr_en(corr_en), .fcw_frac(fcw_frac),
    .cnt_err(cnt_err), .tdc_diff(tdc_diff), .tdc_ovf(tdc_ovf),
    .tdc_unf(tdc_unf), .err_out(err_out), .corr_flag(corr_flag)
  );

  function automatic int flag_val(input logic [1:0] f);
    return int'($signed(f));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected correction in counts and next flag, from the requirements
  function automatic int model_corr(input bit en, input int frac, input int cnt,
                                    input bit ovf, input bit unf, input int flag,
                                    output int nflag);
    bit rev  = frac[FRAC_W-1];
    int s    = rev ? -1 : 1;
    bit step = rev ? (cnt == 0) : (cnt == 1);
    bit wrap = rev ? unf : ovf;
    int c    = 0;
    nflag = flag;
    if (!en) nflag = 0;
    else if (cnt == 0 || cnt == 1) begin
      if (wrap && !step && flag != -s) begin c = s;  nflag = flag - s; end
      else if (step && !wrap && flag != s) begin c = -s; nflag = flag + s; end
    end
    return c;
  endfunction

  // Apply one sample, wait one edge, compare; returns expected error
  task automatic cyc(input string req, input bit en, input int frac, input int cnt,
                     input int tdc, input bit ovf, input bit unf);
    int c, nf, exp_err;
    corr_en  = en;
    fcw_frac = FRAC_W'(frac);
    cnt_err  = CNT_W'(cnt);
    tdc_diff = TDC_W'(tdc);
    tdc_ovf  = ovf;
    tdc_unf  = unf;
    c = model_corr(en, frac, cnt, ovf, unf, m_flag, nf);
    exp_err = frac - (cnt + c) * ONE - tdc;
    @(posedge clk);
    #1;
    m_flag = nf;
    check({req, " err"}, int'($signed(err_out)), exp_err);
    check({req, " flag"}, flag_val(corr_flag), m_flag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; corr_en = 1'b1; fcw_frac = '0; cnt_err = '0;
    tdc_diff = '0; tdc_ovf = 1'b0; tdc_unf = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset err", int'($signed(err_out)), 0);
    check("R1 reset flag", flag_val(corr_flag), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 post-reset flag", flag_val(corr_flag), 0);

    // R2: plain locked sweep at fraction 0.25, step aligned with overflow
    cyc("R2 sweep", 1, 4, 0, 4, 0, 0);
    cyc("R2 sweep", 1, 4, 1, -12, 1, 0);
    cyc("R8 aligned", 1, 4, 0, 4, 0, 0);

    // R4/R5: skewed overflow then late counter step
    cyc("R4 early wrap", 1, 4, 0, -12, 1, 0);
    check("R4 cancelled", int'($signed(err_out)), 0);
    check("R4 flag -1", flag_val(corr_flag), -1);
    cyc("R5 late step", 1, 4, 1, 4, 0, 0);
    check("R5 cancelled", int'($signed(err_out)), 0);
    check("R5 flag back", flag_val(corr_flag), 0);

    // R7: held genuine step, only the first sample corrected
    cyc("R7 first", 1, 4, 1, 4, 0, 0);
    check("R7 flag +1", flag_val(corr_flag), 1);
    cyc("R7 second", 1, 4, 1, 4, 0, 0);
    check("R7 passes", int'($signed(err_out)), 4 - ONE - 4);
    cyc("R7 third", 1, 4, 1, 4, 0, 0);

    // R3: unlocked sample holds the +1 flag
    cyc("R3 unlocked", 1, 4, 5, 3, 1, 0);
    cyc("R3 unlocked neg", 1, 4, -3, -7, 0, 0);
    check("R3 flag held", flag_val(corr_flag), 1);

    // R9: bypass clears the flag
    cyc("R9 bypass", 0, 4, 0, -12, 1, 0);
    check("R9 flag cleared", flag_val(corr_flag), 0);

    // R10: underflow ignored in the forward half
    cyc("R10 unf ignored", 1, 4, 0, 4, 0, 1);

    // R6: reverse half, fraction 0.75
    cyc("R6 sweep", 1, 12, 1, -4, 0, 0);
    cyc("R6 early unf", 1, 12, 1, 12, 0, 1);
    check("R6 flag +1", flag_val(corr_flag), 1);
    cyc("R6 late step", 1, 12, 0, -4, 0, 0);
    check("R6 flag back", flag_val(corr_flag), 0);
    cyc("R10 ovf ignored", 1, 12, 0, -4, 1, 0);
    cyc("R7 rev hold", 1, 12, 0, -4, 0, 0);
    check("R7 rev flag", flag_val(corr_flag), -1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int r   = int'($urandom_range(0, 9));
      int cnt = (r < 7) ? int'($urandom_range(0, 1))
                        : int'($urandom_range(0, (1 << CNT_W) - 1)) - (1 << (CNT_W - 1));
      int tdc = int'($urandom_range(0, 2 * ONE)) - ONE;
      cyc("R2 random", ($urandom_range(0, 15) != 0),
          int'($urandom_range(0, ONE - 1)), cnt, tdc,
          ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0));
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule